// File: doc/BRIEF.md
# Multidimensional Permuted Index Generator

This block walks a vector loop of `cfg_vl` steps and gives out one remapped element index per clock. The flat step count is seen as up to three nested axes, x, y and z, with a programmable size on each. The axes are stepped like an odometer, in a nesting order chosen by the caller. Any axis can be mirrored. The index is built from the axis counters, and the y and x terms can each be switched off. If the loop is longer than the product of the axis sizes, the pattern wraps and repeats.

A pulse on `start` captures the whole configuration and clears the counters. The block first advances its counters by `cfg_offset` steps, plus `cfg_resume` more steps when a loop that was interrupted is picked up again. This replay runs one step per clock, and `busy` stays high while it runs. The block then emits steps `cfg_resume` to `cfg_vl`-1, one per clock.

A flag on each output reports when the index added to a base register number reaches past a register file of `RF_SIZE` entries. The surrounding logic uses this flag to raise its own fault.

Top module: `mdim_index_gen`

## Requirements
- R1: After reset, `out_valid`, `busy`, `out_done` and `out_overflow` are all low.
- R2: Axis codes are x=0, y=1 and z=2. `cfg_order[1:0]` names the innermost axis, `cfg_order[3:2]` the middle axis and `cfg_order[5:4]` the outermost. Every step increments the innermost counter. A counter that passes its size-1 value returns to 0 and carries into the next axis in the order.
- R3: Each axis size is its `cfg_*dim_m1` field plus 1. When bit a of `cfg_invert` is set (bit0=x, bit1=y, bit2=z), the term for axis a is size-1-counter. Otherwise the term is the counter.
- R4: The index is formed in three steps. It starts as the z term. If `cfg_use_y` is set, it becomes index*ysize + y term. Then, if `cfg_use_x` is set, it becomes index*xsize + x term.
- R5: After `start`, `busy` is high for exactly `cfg_offset`+`cfg_resume` cycles, with one counter advance per cycle, and `out_valid` stays low while `busy` is high.
- R6: The output for step s equals the index after `cfg_offset`+s advances from zero. `out_step` carries s, and the first step emitted is `cfg_resume`.
- R7: Exactly `cfg_vl`-`cfg_resume` valid outputs appear, on consecutive cycles right after `busy` falls. When `cfg_vl` exceeds the product of the axis sizes, the pattern repeats.
- R8: `out_done` is high only on the cycle that carries the valid output for step `cfg_vl`-1.
- R9: `out_overflow` is high exactly when `out_valid` is high and `cfg_base` + index >= `RF_SIZE`.
- R10: If `cfg_vl` is 0, or if `cfg_resume` >= `cfg_vl`, no valid output and no `out_done` appear.
- R11: A `start` pulse during a run abandons that run, and the new configuration's sequence follows from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Captures configuration and clears counters |
| cfg_xdim_m1 | input | DIM_W | x size minus one |
| cfg_ydim_m1 | input | DIM_W | y size minus one |
| cfg_zdim_m1 | input | DIM_W | z size minus one |
| cfg_order | input | 6 | Nesting order, three 2-bit axis codes, innermost in bits 1:0 |
| cfg_invert | input | 3 | Per-axis mirror flags |
| cfg_use_y | input | 1 | Include the y term |
| cfg_use_x | input | 1 | Include the x term |
| cfg_offset | input | VL_W | Steps to pre-advance |
| cfg_vl | input | VL_W | Loop length |
| cfg_resume | input | VL_W | Step number to resume from |
| cfg_base | input | BASE_W | Base register number for the overflow test |
| busy | output | 1 | Replay in progress |
| out_valid | output | 1 | An index is presented |
| out_index | output | 3*DIM_W | Remapped index |
| out_step | output | VL_W | Step number of the presented index |
| out_done | output | 1 | Last step of the loop |
| out_overflow | output | 1 | Base plus index is outside the register file |

## Verification
The hardest state to reach from the ports is a resumed loop whose replay carries through every axis in a permuted order with a mirrored axis. Only then do replayed counters, inversion and nesting order all meet on the first index emitted. The stimulus table includes a three-axis case with reversed nesting, x mirrored, a nonzero offset and a resume point. Its first index was worked out by hand. The bench also runs a restart in the middle of a run, and the empty and already-finished loops, so that the paths that never emit can be checked too.

// File: rtl/mdim_pkg.sv
package mdim_pkg;
   localparam int unsigned N_AXES = 3;

   typedef enum logic [1:0] {
      GEN_IDLE = 2'd0,
      GEN_ROLL = 2'd1,
      GEN_RUN  = 2'd2
   } gen_state_e;
endpackage

// File: rtl/mdim_axis_chain.sv
module mdim_axis_chain #(
   parameter int unsigned DIM_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   adv,
   input  logic [2:0][DIM_W-1:0]  lim_m1,
   input  logic [5:0]             order,
   output logic [2:0][DIM_W-1:0]  cnt
);
   import mdim_pkg::*;

   logic [2:0][DIM_W-1:0] nxt;
   logic                  carry;
   logic                  absorbed;

   // odometer step: carry walks the axes in the programmed nesting order
   always_comb begin
      nxt   = cnt;
      carry = adv;
      for (int p = 0; p < int'(N_AXES); p++) begin
         absorbed = 1'b0;
         for (int a = 0; a < int'(N_AXES); a++) begin
            if (carry && (order[2*p +: 2] == 2'(a))) begin
               if (cnt[a] == lim_m1[a]) begin
                  nxt[a] = '0;
               end else begin
                  nxt[a]   = cnt[a] + 1'b1;
                  absorbed = 1'b1;
               end
            end
         end
         if (absorbed) carry = 1'b0;
      end
   end

   for (genvar a = 0; a < int'(N_AXES); a++) begin : g_axis
      logic [DIM_W-1:0] cnt_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cnt_r <= '0;
         else if (clr) cnt_r <= '0;
         else          cnt_r <= nxt[a];
      end
      assign cnt[a] = cnt_r;
   end
endmodule

// File: rtl/mdim_index_compose.sv
module mdim_index_compose #(
   parameter int unsigned DIM_W = 4,
   parameter int unsigned IDX_W = 3 * DIM_W
) (
   input  logic [2:0][DIM_W-1:0] cnt,
   input  logic [2:0][DIM_W-1:0] lim_m1,
   input  logic [2:0]            invert,
   input  logic                  use_y,
   input  logic                  use_x,
   output logic [IDX_W-1:0]      index
);
   import mdim_pkg::*;

   logic [2:0][DIM_W-1:0] term;
   logic [IDX_W-1:0]      acc;

   for (genvar a = 0; a < int'(N_AXES); a++) begin : g_term
      assign term[a] = invert[a] ? (lim_m1[a] - cnt[a]) : cnt[a];
   end

   always_comb begin
      acc = IDX_W'(term[2]);
      if (use_y) acc = acc * (IDX_W'(lim_m1[1]) + 1'b1) + IDX_W'(term[1]);
      if (use_x) acc = acc * (IDX_W'(lim_m1[0]) + 1'b1) + IDX_W'(term[0]);
   end

   assign index = acc;
endmodule

// File: rtl/mdim_index_gen.sv
module mdim_index_gen #(
   parameter int unsigned DIM_W   = 4,
   parameter int unsigned VL_W    = 8,
   parameter int unsigned BASE_W  = 8,
   parameter int unsigned RF_SIZE = 64,
   localparam int unsigned IDX_W  = 3 * DIM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DIM_W-1:0]  cfg_xdim_m1,
   input  logic [DIM_W-1:0]  cfg_ydim_m1,
   input  logic [DIM_W-1:0]  cfg_zdim_m1,
   input  logic [5:0]        cfg_order,
   input  logic [2:0]        cfg_invert,
   input  logic              cfg_use_y,
   input  logic              cfg_use_x,
   input  logic [VL_W-1:0]   cfg_offset,
   input  logic [VL_W-1:0]   cfg_vl,
   input  logic [VL_W-1:0]   cfg_resume,
   input  logic [BASE_W-1:0] cfg_base,
   output logic              busy,
   output logic              out_valid,
   output logic [IDX_W-1:0]  out_index,
   output logic [VL_W-1:0]   out_step,
   output logic              out_done,
   output logic              out_overflow
);
   import mdim_pkg::*;

   localparam int unsigned SUM_W = ((IDX_W > BASE_W) ? IDX_W : BASE_W) + 1;

   if (DIM_W < 1 || VL_W < 1 || BASE_W < 1) begin : g_bad_width
      $error("mdim_index_gen: widths must be at least 1");
   end
   if (RF_SIZE < 1 || RF_SIZE >= (1 << SUM_W)) begin : g_bad_rf
      $error("mdim_index_gen: RF_SIZE out of range");
   end

   gen_state_e            state_q;
   logic [2:0][DIM_W-1:0] lim_q;
   logic [5:0]            order_q;
   logic [2:0]            inv_q;
   logic                  use_y_q, use_x_q;
   logic [VL_W-1:0]       vl_q, step_q;
   logic [BASE_W-1:0]     base_q;
   logic [VL_W:0]         roll_q, roll_n;
   logic [2:0][DIM_W-1:0] cnt;
   logic [IDX_W-1:0]      index;
   logic [SUM_W-1:0]      reach;
   logic                  adv;

   assign roll_n = {1'b0, cfg_offset} + {1'b0, cfg_resume};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= GEN_IDLE;
         lim_q   <= '0;
         order_q <= 6'h24;
         inv_q   <= '0;
         use_y_q <= 1'b0;
         use_x_q <= 1'b0;
         vl_q    <= '0;
         step_q  <= '0;
         base_q  <= '0;
         roll_q  <= '0;
      end else if (start) begin
         lim_q   <= {cfg_zdim_m1, cfg_ydim_m1, cfg_xdim_m1};
         order_q <= cfg_order;
         inv_q   <= cfg_invert;
         use_y_q <= cfg_use_y;
         use_x_q <= cfg_use_x;
         vl_q    <= cfg_vl;
         base_q  <= cfg_base;
         step_q  <= cfg_resume;
         roll_q  <= roll_n;
         if (roll_n != '0)             state_q <= GEN_ROLL;
         else if (cfg_resume < cfg_vl) state_q <= GEN_RUN;
         else                          state_q <= GEN_IDLE;
      end else begin
         unique case (state_q)
            GEN_ROLL: begin
               roll_q <= roll_q - 1'b1;
               if (roll_q == {{VL_W{1'b0}}, 1'b1})
                  state_q <= (step_q < vl_q) ? GEN_RUN : GEN_IDLE;
            end
            GEN_RUN: begin
               step_q <= step_q + 1'b1;
               if (step_q == vl_q - 1'b1) state_q <= GEN_IDLE;
            end
            default: ;
         endcase
      end
   end

   assign adv = !start && (state_q == GEN_ROLL || state_q == GEN_RUN);

   mdim_axis_chain #(.DIM_W(DIM_W)) u_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (start),
      .adv    (adv),
      .lim_m1 (lim_q),
      .order  (order_q),
      .cnt    (cnt)
   );

   mdim_index_compose #(.DIM_W(DIM_W), .IDX_W(IDX_W)) u_compose (
      .cnt    (cnt),
      .lim_m1 (lim_q),
      .invert (inv_q),
      .use_y  (use_y_q),
      .use_x  (use_x_q),
      .index  (index)
   );

   assign reach        = SUM_W'(base_q) + SUM_W'(index);
   assign busy         = (state_q == GEN_ROLL);
   assign out_valid    = (state_q == GEN_RUN);
   assign out_index    = index;
   assign out_step     = step_q;
   assign out_done     = out_valid && (step_q == vl_q - 1'b1);
   assign out_overflow = out_valid && (reach >= SUM_W'(RF_SIZE));
endmodule

// File: rtl/mdim_index_gen_chk.sv
module mdim_index_gen_chk #(
   parameter int unsigned VL_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic            out_valid,
   input logic            out_done,
   input logic            out_overflow,
   input logic [VL_W-1:0] out_step
);
   // R5: replay and output never overlap
   a_r5_no_valid_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !out_valid);

   // R8: done only marks a presented output
   a_r8_done_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> out_valid);

   // R8: nothing follows the last step unless restarted
   a_r8_done_then_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (out_done && !start) |=> !out_valid);

   // R7: steps advance by one on consecutive cycles
   a_r7_step_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_done && !start) |=> (out_valid && out_step == $past(out_step) + 1'b1));

   // R9: overflow is only reported on a presented output
   a_r9_overflow_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_overflow |-> out_valid);
endmodule

bind mdim_index_gen mdim_index_gen_chk #(.VL_W(VL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .busy         (busy),
   .out_valid    (out_valid),
   .out_done     (out_done),
   .out_overflow (out_overflow),
   .out_step     (out_step)
);

// File: tb/mdim_index_gen_tb.sv
module mdim_index_gen_tb;
   typedef struct packed {
      logic [3:0]  xm, ym, zm;
      logic [5:0]  ord;
      logic [2:0]  inv;
      logic        uy, ux;
      logic [7:0]  off, vl, res, base;
      logic [11:0] first;
   } vec_t;

   // order codes: 6'h24 = x,y,z (x innermost); 6'h21 = y,x,z; 6'h06 = z,y,x
   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{4'd2, 4'd1, 4'd0, 6'h24, 3'b000, 1'b1, 1'b1, 8'd0, 8'd6,  8'd0, 8'd0,  12'd0},
      '{4'd2, 4'd1, 4'd0, 6'h21, 3'b010, 1'b1, 1'b1, 8'd0, 8'd6,  8'd0, 8'd0,  12'd3},
      '{4'd3, 4'd3, 4'd0, 6'h24, 3'b000, 1'b1, 1'b1, 8'd2, 8'd4,  8'd0, 8'd0,  12'd2},
      '{4'd3, 4'd3, 4'd0, 6'h21, 3'b000, 1'b1, 1'b1, 8'd0, 8'd16, 8'd0, 8'd0,  12'd0},
      '{4'd2, 4'd1, 4'd1, 6'h06, 3'b001, 1'b1, 1'b1, 8'd1, 8'd12, 8'd5, 8'd0,  12'd4},
      '{4'd1, 4'd1, 4'd2, 6'h24, 3'b000, 1'b0, 1'b0, 8'd0, 8'd12, 8'd0, 8'd0,  12'd0},
      '{4'd3, 4'd3, 4'd0, 6'h21, 3'b000, 1'b1, 1'b1, 8'd0, 8'd16, 8'd0, 8'd60, 12'd0},
      '{4'd1, 4'd0, 4'd0, 6'h24, 3'b000, 1'b1, 1'b1, 8'd0, 8'd5,  8'd0, 8'd0,  12'd0}
   };
   localparam int RF = 64;

   logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [3:0]  xm = '0, ym = '0, zm = '0;
   logic [5:0]  ord = 6'h24;
   logic [2:0]  inv = '0;
   logic        uy = 1'b0, ux = 1'b0;
   logic [7:0]  off = '0, vl = '0, res = '0, base = '0;
   logic        busy, valid, done, ovf;
   logic [11:0] idx;
   logic [7:0]  step;
   int          n_chk = 0, n_bad = 0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   mdim_index_gen u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_xdim_m1(xm), .cfg_ydim_m1(ym), .cfg_zdim_m1(zm),
      .cfg_order(ord), .cfg_invert(inv), .cfg_use_y(uy), .cfg_use_x(ux),
      .cfg_offset(off), .cfg_vl(vl), .cfg_resume(res), .cfg_base(base),
      .busy(busy), .out_valid(valid), .out_index(idx), .out_step(step),
      .out_done(done), .out_overflow(ovf)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // independent model of the requirements: odometer from zero, then compose
   function automatic int ref_idx(vec_t c, int advances);
      int lim [3];
      int cnt [3];
      int t   [3];
      int r;
      lim[0] = int'(c.xm) + 1; lim[1] = int'(c.ym) + 1; lim[2] = int'(c.zm) + 1;
      cnt[0] = 0; cnt[1] = 0; cnt[2] = 0;
      for (int k = 0; k < advances; k++) begin
         for (int p = 0; p < 3; p++) begin
            int ax;
            ax = int'(c.ord[2*p +: 2]);
            cnt[ax] = cnt[ax] + 1;
            if (cnt[ax] != lim[ax]) break;
            cnt[ax] = 0;
         end
      end
      for (int a = 0; a < 3; a++) t[a] = c.inv[a] ? (lim[a] - 1 - cnt[a]) : cnt[a];
      r = t[2];
      if (c.uy) r = r * lim[1] + t[1];
      if (c.ux) r = r * lim[0] + t[0];
      return r;
   endfunction

   task automatic kick(vec_t c);
      @(negedge clk);
      xm = c.xm; ym = c.ym; zm = c.zm; ord = c.ord; inv = c.inv;
      uy = c.uy; ux = c.ux; off = c.off; vl = c.vl; res = c.res; base = c.base;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic collect(vec_t c, bit chk_first);
      int nroll, nout, nb, nv, ndone, e;
      nroll = int'(c.off) + int'(c.res);
      nout  = (c.vl > c.res) ? int'(c.vl) - int'(c.res) : 0;
      nb = 0; nv = 0; ndone = 0;
      for (int cyc = 0; cyc < nroll + int'(c.vl) + 4; cyc++) begin
         if (cyc > 0) @(negedge clk);
         if (busy) nb++;
         if (valid) begin
            e = ref_idx(c, int'(c.off) + int'(c.res) + nv);
            check(!busy, "R5 valid during busy", int'(busy), 0);
            check(cyc == nroll + nv, "R7 consecutive outputs cycle", cyc, nroll + nv);
            check(int'(idx) == e, "R2/R3/R4/R6 index", int'(idx), e);
            check(int'(step) == int'(c.res) + nv, "R6 step number", int'(step), int'(c.res) + nv);
            check(ovf == ((int'(c.base) + e) >= RF), "R9 overflow", int'(ovf),
                  int'((int'(c.base) + e) >= RF));
            check(done == (nv == nout - 1), "R8 done placement", int'(done), int'(nv == nout - 1));
            if (chk_first && nv == 0)
               check(int'(idx) == int'(c.first), "R6 first index (table)", int'(idx), int'(c.first));
            if (done) ndone++;
            nv++;
         end else begin
            if (done) ndone++;
            if (ovf) check(1'b0, "R9 overflow without valid", 1, 0);
         end
      end
      check(nb == nroll, "R5 busy cycles", nb, nroll);
      check(nv == nout, "R7/R10 valid count", nv, nout);
      check(ndone == (nout > 0 ? 1 : 0), "R8/R10 done count", ndone, (nout > 0 ? 1 : 0));
   endtask

   initial begin
      for (int i = 0; i < 150000; i++) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      vec_t v;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!valid && !busy && !done && !ovf, "R1 reset outputs", int'({valid, busy, done, ovf}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!valid && !busy && !done && !ovf, "R1 idle after reset", int'({valid, busy, done, ovf}), 0);

      for (int i = 0; i < NV; i++) begin
         kick(VEC[i]);
         collect(VEC[i], 1'b1);
      end

      // R10: empty loop
      v = VEC[0]; v.vl = 8'd0; v.off = 8'd3;
      kick(v); collect(v, 1'b0);
      // R10: resume point already past the end
      v = VEC[0]; v.vl = 8'd4; v.res = 8'd4;
      kick(v); collect(v, 1'b0);
      // R6: resume on last step with full carry chain
      v = VEC[4]; v.res = 8'd11; v.off = 8'd0;
      kick(v); collect(v, 1'b0);

      // R11: restart in the middle of a run
      kick(VEC[3]);
      repeat (3) @(negedge clk);
      check(valid, "R11 first run active", int'(valid), 1);
      kick(VEC[2]);
      collect(VEC[2], 1'b1);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule